// File: doc/BRIEF.md
# Bus Slave Register File Front End

This block is the data-transfer end of a 16-bit asynchronous bus slave on a data acquisition board, entered once board selection has already happened. A seven-bit word address picks one of 128 sixteen-bit registers, which together cover 256 bytes of bus space. A write/read line sets the direction. Two active-low byte strobes say which byte lanes take part in the transfer. The block raises an acknowledge for each transfer and keeps it up until the master releases the strobes.

Word address 0 holds a combined control/status location. A write there loads the control register, whose outputs set the board's operating mode. A read there returns a status word. That word carries external flag inputs in its upper byte and a copy of the low control byte in its lower byte. The other 127 addresses are plain storage that stands in for the rest of the board's registers.

The system reset input is active low. It acts at once and is released in step with the clock. While it is applied, the block asserts a clear signal for the board's timers and flags.

Top module: `acq_bus_slave`

## Requirements
- R1: While reset is applied, ack_o, data_oe_o and ctrl_o are all zero, and data_o is zero.
- R2: timer_clr_o is high while rst_n is low. It stays high through the first rising clock edge after rst_n rises and goes low at the second.
- R3: ack_o rises at the second rising edge after a strobe goes active (one edge to sample it, one to answer). It stays high while any strobe is held. It falls at the second rising edge after all strobes are released.
- R4: A full-word write (ds_ni = 2'b00) to any address from 1 to 127 is returned by a later read of that address. Separate addresses do not alias.
- R5: On a write, ds_ni[0] low enables the low byte (bits 7:0) and ds_ni[1] low enables the high byte (bits 15:8). A byte lane that is not enabled keeps its stored value.
- R6: On a read, a byte lane whose strobe is inactive returns zero.
- R7: A write to address 0 loads ctrl_o lane by lane, in the same cycle as ack_o rises. A write to any other address leaves ctrl_o unchanged.
- R8: A read of address 0 returns {stat_i, ctrl_o[7:0]}. This status word is sampled at the edge where ack_o rises. The upper control byte is not returned.
- R9: data_oe_o is high only while ack_o is high for a read. It is never high for a write. data_o is zero whenever data_oe_o is low.
- R10: Each strobe assertion performs exactly one transfer. A change to data_i or addr_i while the strobes are held has no effect.
- R11: Applying reset during a transfer drops ack_o and data_oe_o at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board system clock |
| rst_n | input | 1 | System reset, active low, asynchronous assertion |
| addr_i | input | 7 | Word address of the transfer |
| wr_i | input | 1 | 1 = write into the board, 0 = read from the board |
| ds_ni | input | 2 | Byte strobes, active low; bit 0 = low byte, bit 1 = high byte |
| data_i | input | 16 | Write data from the bus transceiver |
| data_o | output | 16 | Read data toward the bus transceiver |
| data_oe_o | output | 1 | Transceiver drive enable for read data |
| ack_o | output | 1 | Transfer acknowledge |
| ctrl_o | output | 16 | Latched control register outputs |
| stat_i | input | 8 | Status flags shown in the upper byte of the status word |
| timer_clr_o | output | 1 | Clear for on-board timers and flags |

## Verification
Two events can land in the same cycle. One is the answer edge of a status read, where the word is sampled. The other is a change on the external flag inputs. The bench changes stat_i one edge after the read strobe has been sampled, so the new flags arrive just before the answering edge, and it then checks that the returned word holds the new flags beside the current control byte. The same test also puts a control write and a flag change in one cycle, then confirms with a later status read that both appear.

// File: rtl/acq_bus_pkg.sv
package acq_bus_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } bus_st_e;

  localparam int unsigned LANE_W = 8;

endpackage

// File: rtl/acq_bus_capture.sv
module acq_bus_capture #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 7,
  localparam int unsigned LANES = DATA_W / acq_bus_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  ds_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic              stb_o,
  output logic [LANES-1:0]  lane_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);

  logic [LANES-1:0] lane_d;

  always_comb begin
    lane_d = ~ds_ni;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_o  <= 1'b0;
      lane_o <= '0;
      wr_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      stb_o  <= |lane_d;
      lane_o <= lane_d;
      wr_o   <= wr_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end

  AST_STB_MATCHES_LANES: assert property (@(posedge clk) disable iff (!rst_ni)
    stb_o == (lane_o != '0)); // R3

endmodule

// File: rtl/acq_bus_ctl.sv
module acq_bus_ctl
  import acq_bus_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic wr_i,
  output logic xfer_o,
  output logic ack_o,
  output logic oe_o
);

  bus_st_e st_q, st_d;
  logic    oe_q, oe_d;

  always_comb begin
    st_d   = st_q;
    oe_d   = oe_q;
    xfer_o = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (stb_i) begin
          xfer_o = 1'b1;
          st_d   = ST_ACK;
          oe_d   = !wr_i;
        end
      end
      ST_ACK: begin
        if (!stb_i) begin
          st_d = ST_IDLE;
          oe_d = 1'b0;
        end
      end
      default: begin
        st_d = ST_IDLE;
        oe_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      st_q <= st_d;
      oe_q <= oe_d;
    end
  end

  assign ack_o = (st_q == ST_ACK);
  assign oe_o  = oe_q;

  AST_ACK_FROM_STB: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(stb_i)); // R3
  AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_o && stb_i) |=> ack_o); // R3
  AST_OE_ONLY_ACK: assert property (@(posedge clk) disable iff (!rst_ni)
    oe_o |-> ack_o); // R9
  AST_ONE_XFER: assert property (@(posedge clk) disable iff (!rst_ni)
    xfer_o |=> !xfer_o); // R10

endmodule

// File: rtl/acq_bus_regs.sv
module acq_bus_regs #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned STAT_W = 8,
  localparam int unsigned LANES = DATA_W / acq_bus_pkg::LANE_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              xfer_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  lane_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o
);

  localparam int unsigned LW = acq_bus_pkg::LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mask, merged, status, rd_word;
  logic [DATA_W-1:0] ctrl_q, ctrl_d, rdata_q, rdata_d;
  logic              csr_sel, mem_we, ctrl_we, rd_en;

  always_comb begin
    for (int g = 0; g < int'(LANES); g++) begin
      mask[g*LW +: LW] = {LW{lane_i[g]}};
    end
  end

  always_comb begin
    csr_sel = (addr_i == '0);
    mem_we  = xfer_i && wr_i && !csr_sel;
    ctrl_we = xfer_i && wr_i && csr_sel;
    rd_en   = xfer_i && !wr_i;
    merged  = (mem[addr_i] & ~mask) | (wdata_i & mask);
    status  = {stat_i, ctrl_q[DATA_W-STAT_W-1:0]};
    rd_word = csr_sel ? status : mem[addr_i];
    ctrl_d  = ctrl_we ? ((ctrl_q & ~mask) | (wdata_i & mask)) : ctrl_q;
    rdata_d = rd_en ? (rd_word & mask) : rdata_q;
  end

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[addr_i] <= merged;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      rdata_q <= rdata_d;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = rdata_q;

  AST_CTRL_ONLY_CSR: assert property (@(posedge clk) disable iff (!rst_ni)
    !(xfer_i && wr_i && addr_i == '0) |=> $stable(ctrl_o)); // R7
  AST_RD_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    (xfer_i && !wr_i && !lane_i[0]) |=> (rdata_o[LW-1:0] == '0)); // R6

endmodule

// File: rtl/acq_bus_slave.sv
module acq_bus_slave #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned STAT_W = 8,
  localparam int unsigned LANES = DATA_W / acq_bus_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  ds_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              ack_o,
  output logic [DATA_W-1:0] ctrl_o,
  input  logic [STAT_W-1:0] stat_i,
  output logic              timer_clr_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic              stb_s, wr_s, xfer, oe;
  logic [LANES-1:0]  lane_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] wdata_s, rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n   = rst_sync_q[1];
  assign timer_clr_o = !rst_int_n;

  acq_bus_capture #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_cap (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .ds_ni  (ds_ni),
    .data_i (data_i),
    .stb_o  (stb_s),
    .lane_o (lane_s),
    .wr_o   (wr_s),
    .addr_o (addr_s),
    .data_o (wdata_s)
  );

  acq_bus_ctl u_ctl (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .stb_i  (stb_s),
    .wr_i   (wr_s),
    .xfer_o (xfer),
    .ack_o  (ack_o),
    .oe_o   (oe)
  );

  acq_bus_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_W(STAT_W)) u_regs (
    .clk     (clk),
    .rst_ni  (rst_int_n),
    .xfer_i  (xfer),
    .wr_i    (wr_s),
    .addr_i  (addr_s),
    .lane_i  (lane_s),
    .wdata_i (wdata_s),
    .stat_i  (stat_i),
    .rdata_o (rdata),
    .ctrl_o  (ctrl_o)
  );

  assign data_oe_o = oe;
  assign data_o    = oe ? rdata : '0;

  AST_CLR_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !timer_clr_o |=> !timer_clr_o); // R2
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe_o |-> (data_o == '0)); // R9
  AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (timer_clr_o)
    $rose(data_oe_o) |-> !$past(wr_s)); // R9

endmodule

// File: tb/sim_acq_bus_slave.sv
module sim_acq_bus_slave;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  addr_i;
  logic        wr_i;
  logic [1:0]  ds_ni;
  logic [15:0] data_i;
  logic [15:0] data_o;
  logic        data_oe_o, ack_o, timer_clr_o;
  logic [15:0] ctrl_o;
  logic [7:0]  stat_i;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  acq_bus_slave u0 (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_i(wr_i), .ds_ni(ds_ni),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .ack_o(ack_o),
    .ctrl_o(ctrl_o), .stat_i(stat_i), .timer_clr_o(timer_clr_o)
  );

  typedef struct packed {
    logic        w;
    logic [6:0]  a;
    logic [1:0]  dsn;
    logic [15:0] wd;
    logic [15:0] ex;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 7'd5,   2'b00, 16'h1234, 16'h0000},
    '{1'b0, 7'd5,   2'b00, 16'h0000, 16'h1234},
    '{1'b1, 7'd5,   2'b10, 16'hABCD, 16'h0000},
    '{1'b0, 7'd5,   2'b00, 16'h0000, 16'h12CD},
    '{1'b1, 7'd5,   2'b01, 16'h5E00, 16'h0000},
    '{1'b0, 7'd5,   2'b00, 16'h0000, 16'h5ECD},
    '{1'b0, 7'd5,   2'b10, 16'h0000, 16'h00CD},
    '{1'b0, 7'd5,   2'b01, 16'h0000, 16'h5E00},
    '{1'b1, 7'd127, 2'b00, 16'hBEEF, 16'h0000},
    '{1'b0, 7'd127, 2'b00, 16'h0000, 16'hBEEF},
    '{1'b1, 7'd1,   2'b00, 16'h0F0F, 16'h0000},
    '{1'b0, 7'd1,   2'b00, 16'h0000, 16'h0F0F},
    '{1'b0, 7'd127, 2'b00, 16'h0000, 16'hBEEF},
    '{1'b1, 7'd0,   2'b00, 16'hC33C, 16'h0000},
    '{1'b0, 7'd0,   2'b00, 16'h0000, 16'hA53C}
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Full bus cycle with timing checks; read data compared at the ack edge.
  task automatic access(input logic w, input logic [6:0] a, input logic [1:0] dsn,
                        input logic [15:0] wd, input logic [15:0] ex);
    @(negedge clk);
    wr_i = w; addr_i = a; data_i = wd; ds_ni = dsn;
    @(negedge clk);
    chk(ack_o == 1'b0, "R3 ack early", 16'(ack_o), 16'h0);
    @(negedge clk);
    chk(ack_o == 1'b1, "R3 ack rise", 16'(ack_o), 16'h1);
    chk(data_oe_o == !w, "R9 oe during ack", 16'(data_oe_o), 16'(!w));
    if (!w) chk(data_o == ex, "R4 R5 R6 R8 read data", data_o, ex);
    ds_ni = 2'b11;
    @(negedge clk);
    chk(ack_o == 1'b1, "R3 ack held one edge", 16'(ack_o), 16'h1);
    @(negedge clk);
    chk(ack_o == 1'b0 && data_oe_o == 1'b0, "R3 R9 release", {ack_o, data_oe_o}, 16'h0);
    chk(data_o == 16'h0, "R9 quiet bus", data_o, 16'h0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(timer_clr_o == 1'b1, "R2 clear held first edge", 16'(timer_clr_o), 16'h1);
    @(negedge clk);
    chk(timer_clr_o == 1'b0, "R2 clear released", 16'(timer_clr_o), 16'h0);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr_i = '0; wr_i = 1'b0; ds_ni = 2'b11; data_i = '0; stat_i = 8'hA5;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk(ack_o == 0 && data_oe_o == 0, "R1 reset handshake", {ack_o, data_oe_o}, 16'h0);
    chk(ctrl_o == 16'h0, "R1 reset ctrl", ctrl_o, 16'h0);
    chk(data_o == 16'h0, "R1 reset data", data_o, 16'h0);
    chk(timer_clr_o == 1'b1, "R2 clear in reset", 16'(timer_clr_o), 16'h1);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].w, VECS[i].a, VECS[i].dsn, VECS[i].wd, VECS[i].ex);
    end
    chk(ctrl_o == 16'hC33C, "R7 ctrl loaded", ctrl_o, 16'hC33C);

    // R7: byte-lane control write and non-CSR write leave other bits alone
    access(1'b1, 7'd0, 2'b01, 16'h7700, 16'h0);
    chk(ctrl_o == 16'h773C, "R7 ctrl high lane", ctrl_o, 16'h773C);
    access(1'b1, 7'd3, 2'b00, 16'hFFFF, 16'h0);
    chk(ctrl_o == 16'h773C, "R7 ctrl untouched", ctrl_o, 16'h773C);

    // R10: data and address changed while strobe held
    @(negedge clk);
    wr_i = 1'b1; addr_i = 7'd9; data_i = 16'h1111; ds_ni = 2'b00;
    repeat (3) @(negedge clk);
    data_i = 16'h2222; addr_i = 7'd10;
    repeat (3) @(negedge clk);
    ds_ni = 2'b11;
    repeat (2) @(negedge clk);
    access(1'b0, 7'd9, 2'b00, 16'h0, 16'h1111);
    access(1'b1, 7'd10, 2'b00, 16'h4444, 16'h0);
    access(1'b0, 7'd10, 2'b00, 16'h0, 16'h4444);

    // Concurrency: flags change right before the status read answer edge
    @(negedge clk);
    wr_i = 1'b0; addr_i = 7'd0; ds_ni = 2'b00;
    @(negedge clk);
    stat_i = 8'h5A;
    @(negedge clk);
    chk(data_o == 16'h5A3C, "R8 fresh flags", data_o, 16'h5A3C);
    ds_ni = 2'b11;
    repeat (2) @(negedge clk);
    // Control write with flags changing in the same cycle
    @(negedge clk);
    wr_i = 1'b1; addr_i = 7'd0; data_i = 16'h0081; ds_ni = 2'b10; stat_i = 8'h0F;
    repeat (2) @(negedge clk);
    ds_ni = 2'b11;
    repeat (2) @(negedge clk);
    access(1'b0, 7'd0, 2'b00, 16'h0, 16'h0F81);

    // R11: reset in the middle of a read
    @(negedge clk);
    wr_i = 1'b0; addr_i = 7'd1; ds_ni = 2'b00;
    repeat (2) @(negedge clk);
    chk(ack_o == 1'b1 && data_oe_o == 1'b1, "R11 mid read", {ack_o, data_oe_o}, 16'h3);
    #1 rst_n = 1'b0;
    #1;
    chk(ack_o == 1'b0 && data_oe_o == 1'b0, "R11 async drop", {ack_o, data_oe_o}, 16'h0);
    chk(ctrl_o == 16'h0, "R1 ctrl cleared", ctrl_o, 16'h0);
    ds_ni = 2'b11;
    do_reset();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule